// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block is the interrupt front end of a small processor core. It watches five request lines and a set of control strobes from the core. When the core signals that an instruction has just completed and the bus is not held by another master, the block picks the single most urgent request that is eligible. It reports that choice in the next cycle as a one-cycle accept pulse, a source code and a 16-bit service address.

Each request line has its own trigger rule. The non-maskable line needs a fresh rising edge and must still be high when it is accepted. The edge line is caught in a latch, so it may drop before it is serviced. The two level lines and the external line must be high at the boundary itself. The external line has no fixed address. Accepting it produces an active-low acknowledge pulse, and outside logic answers that pulse with an opcode. A global enable and three per-source masks decide which of the maskable lines may be taken.

Top module: `irq_ctrl`

## Requirements
- R1: After reset `take` is 0, `ack_n` is 1 and `ien` is 0. The three per-source masks reset to masked, so a level line stays untaken even after `en_set`.
- R2: Fixed priority from highest to lowest is `nmi_line`, `edge_line`, `lvl_a_line`, `lvl_b_line`, `ext_line`. `take_src` codes these as 0, 1, 2, 3 and 4.
- R3: `nmi_line` is taken whatever `ien` and the masks hold. It is taken only after a rising edge seen at a clock edge, and only while it stays high up to acceptance. A line held high after its acceptance is not taken again.
- R4: A rising edge on `edge_line` is latched and can be taken after the line has dropped. Its acceptance clears the latch. A write with `mask_data[4]`=1 also clears the latch.
- R5: `lvl_a_line`, `lvl_b_line` and `ext_line` are taken only if they are high in the boundary cycle.
- R6: `en_set` sets `ien`. `en_clr` clears it, and `en_clr` wins over `en_set` when both are high. Acceptance of any source other than `nmi_line` clears `ien`, while acceptance of `nmi_line` leaves it as it was. With `ien`=0, no source other than `nmi_line` is taken.
- R7: A `mask_wr` pulse with `mask_data[3]`=1 loads the masks: bit 2 masks `edge_line`, bit 1 masks `lvl_a_line` and bit 0 masks `lvl_b_line`, where 1 means masked. With `mask_data[3]`=0 the masks keep their values.
- R8: Accepting `ext_line` gives `take_vec`=0000h and drives `ack_n` low for the single cycle in which `take` is high. `ack_n` stays high for every other source.
- R9: Requests are evaluated only in a cycle with `boundary`=1 and `hold`=0. A pending request that meets a held boundary waits for a later boundary.
- R10: Service addresses are 0024h for `nmi_line`, 003Ch for `edge_line`, 0034h for `lvl_a_line` and 002Ch for `lvl_b_line`.
- R11: `take`, `take_src`, `take_vec` and `ack_n` are registered. They report a decision in the cycle after the boundary and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_line | input | 1 | Non-maskable request, needs an edge and a held level |
| edge_line | input | 1 | Edge-latched maskable request |
| lvl_a_line | input | 1 | Level maskable request, higher of the two |
| lvl_b_line | input | 1 | Level maskable request, lower of the two |
| ext_line | input | 1 | Level request without a vector, lowest priority |
| en_set | input | 1 | Set the global enable |
| en_clr | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Strobe for the mask control word |
| mask_data | input | 5 | Mask control word: [2:0] masks, [3] load masks, [4] clear edge latch |
| hold | input | 1 | Bus held by another master; defers evaluation |
| boundary | input | 1 | Instruction completed in this cycle |
| take | output | 1 | One-cycle pulse: a request was accepted |
| take_src | output | 3 | Code of the accepted source |
| take_vec | output | 16 | Service address of the accepted source |
| ack_n | output | 1 | Active-low acknowledge for the external request |
| ien | output | 1 | Global enable state |

## Verification
Every decision appears one clock after the boundary cycle that caused it. The bench raises `boundary` on a falling edge and drops it on the next falling edge, and it reads `take`, `take_src`, `take_vec`, `ack_n` and `ien` at that second falling edge, one register stage after the boundary. The non-maskable edge and the edge latch each need one clock edge to capture, so request lines are raised at least one full cycle before the boundary, and control writes are applied a cycle before they are relied on. The bench sweeps all 32 request patterns and all 8 mask words, and computes the winner from the priority rule.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC   = 5;
    localparam int SRC_W  = 3;
    localparam int VEC_W  = 16;
    localparam int NMASK  = 3;
    localparam int CTRL_W = 5;

    // mask control word field positions
    localparam int F_MASK_LVB = 0;
    localparam int F_MASK_LVA = 1;
    localparam int F_MASK_EDG = 2;
    localparam int F_LOAD     = 3;
    localparam int F_LCLR     = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_NMI  = 3'd0,
        SRC_EDGE = 3'd1,
        SRC_LVA  = 3'd2,
        SRC_LVB  = 3'd3,
        SRC_EXT  = 3'd4
    } src_e;

    typedef struct packed {
        logic valid;
        src_e src;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        logic [VEC_W-1:0] v;
        case (s)
            SRC_NMI:  v = VEC_W'(16'h0024);
            SRC_EDGE: v = VEC_W'(16'h003C);
            SRC_LVA:  v = VEC_W'(16'h0034);
            SRC_LVB:  v = VEC_W'(16'h002C);
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_cond.sv
module irq_cond (
    input  logic clk,
    input  logic rst,
    input  logic nmi_line,
    input  logic edge_line,
    input  logic accept_nmi,
    input  logic accept_edge,
    input  logic latch_clr,
    output logic nmi_ok,
    output logic edge_pend
);
    logic nmi_prev;
    logic edge_prev;
    logic nmi_pend;
    logic edge_rise;

    assign edge_rise = edge_line & ~edge_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev  <= 1'b1;
            edge_prev <= 1'b1;
        end else begin
            nmi_prev  <= nmi_line;
            edge_prev <= edge_line;
        end
    end

    // non-maskable: armed by a rising edge, dropped when the line falls
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend <= 1'b0;
        end else if (!nmi_line || accept_nmi) begin
            nmi_pend <= 1'b0;
        end else if (!nmi_prev) begin
            nmi_pend <= 1'b1;
        end
    end

    assign nmi_ok = nmi_pend & nmi_line;

    // edge latch: a fresh edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_pend <= 1'b0;
        end else if (edge_rise) begin
            edge_pend <= 1'b1;
        end else if (accept_edge || latch_clr) begin
            edge_pend <= 1'b0;
        end
    end

    p_nmi_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_pend) |-> (!$past(nmi_line, 2) && $past(nmi_line)));

    p_latch_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_pend && !accept_edge && !latch_clr) |=> edge_pend);

    p_latch_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_pend && accept_edge && !edge_rise) |=> !edge_pend);

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              mask_wr,
    input  logic [CTRL_W-1:0] mask_data,
    input  logic              accept_mask,
    output logic              ien,
    output logic [NMASK-1:0]  mask,
    output logic              latch_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ien <= 1'b0;
        end else if (accept_mask || en_clr) begin
            ien <= 1'b0;
        end else if (en_set) begin
            ien <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
        end else if (mask_wr && mask_data[F_LOAD]) begin
            mask <= mask_data[NMASK-1:0];
        end
    end

    assign latch_clr = mask_wr & mask_data[F_LCLR];

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(mask_wr && mask_data[F_LOAD]) |=> $stable(mask));

    p_ien_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (accept_mask || en_clr) |=> !ien);

endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req,
    output pick_t        pick
);
    logic [N:0]   higher;
    logic [N-1:0] grant;

    assign higher[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]    = req[i] & ~higher[i];
            assign higher[i+1] = higher[i] | req[i];
        end
    endgenerate

    always_comb begin
        pick.valid = higher[N];
        pick.src   = SRC_NMI;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) pick.src = src_e'(SRC_W'(i));
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_line,
    input  logic              edge_line,
    input  logic              lvl_a_line,
    input  logic              lvl_b_line,
    input  logic              ext_line,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              mask_wr,
    input  logic [CTRL_W-1:0] mask_data,
    input  logic              hold,
    input  logic              boundary,
    output logic              take,
    output logic [SRC_W-1:0]  take_src,
    output logic [VEC_W-1:0]  take_vec,
    output logic              ack_n,
    output logic              ien
);
    logic             nmi_ok;
    logic             edge_pend;
    logic [NMASK-1:0] mask;
    logic             latch_clr;
    logic [NSRC-1:0]  req;
    pick_t            pick;
    logic             accept;
    logic             accept_nmi;
    logic             accept_edge;
    logic             accept_mask;

    assign accept      = boundary & ~hold & pick.valid;
    assign accept_nmi  = accept & (pick.src == SRC_NMI);
    assign accept_edge = accept & (pick.src == SRC_EDGE);
    assign accept_mask = accept & (pick.src != SRC_NMI);

    irq_cond u_cond (
        .clk        (clk),
        .rst        (rst),
        .nmi_line   (nmi_line),
        .edge_line  (edge_line),
        .accept_nmi (accept_nmi),
        .accept_edge(accept_edge),
        .latch_clr  (latch_clr),
        .nmi_ok     (nmi_ok),
        .edge_pend  (edge_pend)
    );

    irq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .mask_wr    (mask_wr),
        .mask_data  (mask_data),
        .accept_mask(accept_mask),
        .ien        (ien),
        .mask       (mask),
        .latch_clr  (latch_clr)
    );

    // eligibility per source, index equals priority rank
    always_comb begin
        req           = '0;
        req[SRC_NMI]  = nmi_ok;
        req[SRC_EDGE] = edge_pend  & ~mask[F_MASK_EDG] & ien;
        req[SRC_LVA]  = lvl_a_line & ~mask[F_MASK_LVA] & ien;
        req[SRC_LVB]  = lvl_b_line & ~mask[F_MASK_LVB] & ien;
        req[SRC_EXT]  = ext_line & ien;
    end

    irq_arb #(.N(NSRC)) u_arb (
        .req (req),
        .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            take_src <= '0;
            take_vec <= '0;
            ack_n    <= 1'b1;
        end else begin
            take     <= accept;
            take_src <= accept ? pick.src : '0;
            take_vec <= accept ? vec_of(pick.src) : '0;
            ack_n    <= ~(accept & (pick.src == SRC_EXT));
        end
    end

    p_prio_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && pick.src != SRC_NMI) |-> !nmi_ok);

    p_nmi_level_r3: assert property (@(posedge clk) disable iff (rst)
        (take && take_src == SRC_NMI) |-> $past(nmi_line));

    p_level_held_r5: assert property (@(posedge clk) disable iff (rst)
        (take && take_src == SRC_LVB) |-> $past(lvl_b_line));

    p_ien_after_take_r6: assert property (@(posedge clk) disable iff (rst)
        (take && take_src != SRC_NMI) |-> !ien);

    p_ack_ext_only_r8: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> (take && take_src == SRC_EXT && take_vec == '0));

    p_window_r9: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(boundary && !hold));

    p_vec_edge_r10: assert property (@(posedge clk) disable iff (rst)
        (take && take_src == SRC_EDGE) |-> take_vec == 16'h003C);

endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_line = 0, edge_line = 0, lvl_a_line = 0, lvl_b_line = 0, ext_line = 0;
    logic        en_set = 0, en_clr = 0, mask_wr = 0, hold = 0, boundary = 0;
    logic [4:0]  mask_data = '0;
    logic        take, ack_n, ien;
    logic [2:0]  take_src;
    logic [15:0] take_vec;

    int total = 0;
    int bad   = 0;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst(rst), .nmi_line(nmi_line), .edge_line(edge_line),
        .lvl_a_line(lvl_a_line), .lvl_b_line(lvl_b_line), .ext_line(ext_line),
        .en_set(en_set), .en_clr(en_clr), .mask_wr(mask_wr), .mask_data(mask_data),
        .hold(hold), .boundary(boundary), .take(take), .take_src(take_src),
        .take_vec(take_vec), .ack_n(ack_n), .ien(ien)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] want_vec(input int s);
        case (s)
            0: return 16'h0024;
            1: return 16'h003C;
            2: return 16'h0034;
            3: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    // boundary for one cycle, then outputs are read one register stage later
    task automatic fire(input string rq, input int win);
        cyc(); boundary = 1;
        cyc(); boundary = 0;
        chk({rq, " take"}, take, (win >= 0));
        if (win >= 0) begin
            chk({rq, " src"}, take_src, win);
            chk({rq, " vec R10"}, take_vec, want_vec(win));
        end
        chk({rq, " ack_n R8"}, ack_n, !(win == 4));
    endtask

    task automatic write_mask(input logic [4:0] d);
        cyc(); mask_wr = 1; mask_data = d;
        cyc(); mask_wr = 0; mask_data = '0;
    endtask

    task automatic enable();
        cyc(); en_set = 1;
        cyc(); en_set = 0;
    endtask

    task automatic clean();
        cyc(); nmi_line = 0; edge_line = 0; lvl_a_line = 0; lvl_b_line = 0; ext_line = 0;
        write_mask(5'b11000);
        cyc(); en_clr = 1;
        cyc(); en_clr = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 take", take, 0);
        chk("R1 ack_n", ack_n, 1);
        chk("R1 ien", ien, 0);
        enable();
        lvl_b_line = 1;
        cyc();
        fire("R1 masked at reset", -1);
        chk("R1 ien kept", ien, 1);

        // sweep of all request patterns: R2 R3 R5 R6 R8 R10
        for (int p = 0; p < 32; p++) begin
            int win;
            clean();
            cyc();
            nmi_line = p[0]; edge_line = p[1]; lvl_a_line = p[2];
            lvl_b_line = p[3]; ext_line = p[4];
            cyc(); edge_line = 0;
            enable();
            win = -1;
            for (int b = 4; b >= 0; b--) if (p[b]) win = b;
            fire("R2 sweep", win);
            chk("R6 ien after take", ien, (win <= 0));
            cyc();
            chk("R11 pulse ends", take, 0);
        end

        // mask sweep: R7 R4
        for (int m = 0; m < 8; m++) begin
            int win;
            clean();
            write_mask(5'(8 | m));
            cyc(); edge_line = 1; lvl_a_line = 1; lvl_b_line = 1;
            cyc(); edge_line = 0;
            enable();
            win = -1;
            if (!m[0]) win = 3;
            if (!m[1]) win = 2;
            if (!m[2]) win = 1;
            fire("R7 mask sweep", win);
        end

        // R7 write without load bit keeps masks
        clean();
        write_mask(5'b00111);
        cyc(); lvl_b_line = 1;
        enable();
        fire("R7 no load", 3);

        // R4 latch clear bit
        clean();
        cyc(); edge_line = 1;
        cyc(); edge_line = 0;
        write_mask(5'b10000);
        enable();
        fire("R4 latch cleared", -1);

        // R4 accept clears latch
        clean();
        cyc(); edge_line = 1;
        cyc(); edge_line = 0;
        enable();
        fire("R4 edge taken", 1);
        enable();
        fire("R4 latch gone", -1);

        // R3 no re-take while held high, ignores ien and masks
        clean();
        write_mask(5'b01111);
        cyc(); nmi_line = 1;
        cyc();
        fire("R3 nmi masked-off ien", 0);
        chk("R3 ien untouched", ien, 0);
        fire("R3 no second take", -1);
        // R3 edge then drop before boundary
        cyc(); nmi_line = 0;
        cyc(); nmi_line = 1;
        cyc(); nmi_line = 0;
        fire("R3 dropped", -1);

        // R9 hold defers, no boundary no take
        cyc(); nmi_line = 1;
        cyc(); hold = 1;
        fire("R9 held", -1);
        cyc(); hold = 0;
        repeat (2) cyc();
        chk("R9 no boundary", take, 0);
        fire("R9 after hold", 0);
        cyc(); nmi_line = 0;

        // R5 level dropped before boundary
        clean();
        cyc(); lvl_a_line = 1;
        enable();
        cyc(); lvl_a_line = 0;
        fire("R5 dropped", -1);

        // R6 en_clr wins and blocks
        clean();
        cyc(); ext_line = 1; en_set = 1; en_clr = 1;
        cyc(); en_set = 0; en_clr = 0;
        chk("R6 clr wins", ien, 0);
        fire("R6 disabled", -1);
        enable();
        fire("R8 ext taken", 4);
        chk("R6 ext clears ien", ien, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule